// File: doc/BRIEF.md
# Receive Out-of-Frame Monitor

This block watches the out-of-frame indication for one receive port and turns it into a port-wide receive enable and interrupt events. The indication pin is sampled only on one edge of the port's receive clock, and a configuration bit picks whether that edge is rising or falling. Both the receive clock and the pin reach the block asynchronously. The block synchronizes them into the system clock domain, finds the selected receive clock edge there, and compares each new pin sample with the one taken on the previous selected edge.

Two configuration bits set the behaviour. With abort on and interrupts on, a rising sample raises an out-of-frame entry event. The port's receive processing is held off while the sample stays high, and a falling sample raises a frame-recovery event. With abort on and interrupts off, the pin gates receive processing and raises no events. With abort off and interrupts on, the pin serves as a general-purpose serial-port interrupt that fires only on a falling sample, and receive processing is never touched. With both bits off, the pin is ignored. Each event is a one-cycle pulse that also sets a sticky status bit, and the host clears those bits by writing ones. An interrupt line stays high while any status bit is set.

Top module: `oof_monitor`

## Requirements
- R1: The pin is sampled only on the selected receive clock edge: rising when `cfgFallEdge` is 0, falling when it is 1. Pin changes between two selected edges are invisible.
- R2: After reset the previous sample is 0. When a new sample is 1, the previous one was 0, and both `cfgAbort` and `cfgIntEn` are 1, `oofEntryPulse` goes high.
- R3: `rxEnable` is 0 while the latest sample is 1 and `cfgAbort` is 1. In every other case it is 1, which includes `cfgAbort` = 0 with either pin level.
- R4: When a new sample is 0, the previous one was 1, and both configuration bits are 1, `frameRecPulse` goes high and `rxEnable` returns to 1.
- R5: With `cfgAbort` = 0 and `cfgIntEn` = 1, only a 1-to-0 sample change raises `gpIrqPulse`. A 0-to-1 change raises nothing.
- R6: With `cfgIntEn` = 0, no pulse is raised for any pin activity. With both bits 0, the outputs do not respond to the pin at all.
- R7: Every pulse lasts one system clock cycle, and a sample that repeats the previous value raises nothing.
- R8: The status bits are 0 = entry, 1 = recovery, 2 = general-purpose. A pulse sets its bit. Writing a 1 with `statusClrWe` clears that bit. A 0 leaves it unchanged, and a set in the same cycle wins over the clear.
- R9: `irq` is 1 exactly while any status bit is 1.
- R10: A pulse appears SYNC_STAGES+1 system cycles after the selected receive clock edge reaches the pin of the block. Its status bit is set one cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxClk | input | 1 | Port receive clock (asynchronous) |
| oofPin | input | 1 | Out-of-frame indication (asynchronous) |
| cfgFallEdge | input | 1 | 1: sample on falling receive clock edge |
| cfgAbort | input | 1 | Abort receive processing while out of frame |
| cfgIntEn | input | 1 | Interrupt enable |
| statusClrWe | input | 1 | Write strobe for status clear |
| statusClrData | input | 3 | Ones clear the matching status bits |
| rxEnable | output | 1 | Port-wide receive processing enable |
| oofEntryPulse | output | 1 | Out-of-frame entry event |
| frameRecPulse | output | 1 | Frame recovery event |
| gpIrqPulse | output | 1 | General-purpose serial-port event |
| statusBits | output | 3 | Sticky event status |
| irq | output | 1 | High while any status bit is set |

## Verification
An edge driven on the receive clock produces its pulse and any `rxEnable` change SYNC_STAGES+1 cycles later, and the matching status bit follows one cycle after the pulse. A directed test drives stimulus at a falling system clock edge. It checks that nothing has appeared one cycle early, that the pulse is present in the due cycle, and that the status bit is set one cycle after that. The vector table is deliberately insensitive to latency: each entry drives one full receive clock period lasting many system cycles and counts pulses across that whole window. It then checks `rxEnable` and the status bits only after the window has ended, when every result is due.

// File: rtl/oof_mon_pkg.sv
package oof_mon_pkg;

  localparam int IRQ_SRC   = 3;
  localparam int ENTRY_IDX = 0;
  localparam int REC_IDX   = 1;
  localparam int GP_IDX    = 2;

  // decoded from {abort, intEn}
  typedef enum logic [1:0] {
    MODE_IGNORE    = 2'b00,
    MODE_GP_IRQ    = 2'b01,
    MODE_GATE_ONLY = 2'b10,
    MODE_ABORT_IRQ = 2'b11
  } oofMode_t;

  typedef struct packed {
    logic sampleStb;
    logic pinRise;
    logic pinFall;
    logic pinLevel;
  } sampleEvt_t;

  typedef struct packed {
    logic entry;
    logic recover;
    logic gpi;
  } irqStb_t;

endpackage

// File: rtl/oof_mon_sampler.sv
module oof_mon_sampler
  import oof_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxClk,
  input  logic       oofPin,
  input  logic       cfgFallEdge,
  output sampleEvt_t evt
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkSync;
  logic [TOP:0] pinSync;
  logic         clkPrev;
  logic         sampleQ;
  logic         clkNow;
  logic         pinNow;
  logic         clkRise;
  logic         clkFall;
  logic         sampleStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync <= '0;
      pinSync <= '0;
      clkPrev <= 1'b0;
      sampleQ <= 1'b0;
    end else begin
      clkSync <= {clkSync[TOP-1:0], rxClk};
      pinSync <= {pinSync[TOP-1:0], oofPin};
      clkPrev <= clkNow;
      if (sampleStb) sampleQ <= pinNow;
    end
  end

  always_comb begin
    clkNow    = clkSync[TOP];
    pinNow    = pinSync[TOP];
    clkRise   = clkNow & ~clkPrev;
    clkFall   = ~clkNow & clkPrev;
    sampleStb = cfgFallEdge ? clkFall : clkRise;
    evt.sampleStb = sampleStb;
    evt.pinRise   = sampleStb & pinNow & ~sampleQ;
    evt.pinFall   = sampleStb & ~pinNow & sampleQ;
    evt.pinLevel  = sampleQ;
  end

  initial begin
    assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
  end

  assert_sample_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> $stable(sampleQ));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb);

endmodule

// File: rtl/oof_mon_ctrl.sv
module oof_mon_ctrl
  import oof_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sampleEvt_t evt,
  input  logic       cfgAbort,
  input  logic       cfgIntEn,
  output irqStb_t    stb,
  output logic       rxEnable
);

  oofMode_t mode;
  irqStb_t  stbNext;

  always_comb begin
    mode    = oofMode_t'({cfgAbort, cfgIntEn});
    stbNext = '0;
    unique case (mode)
      MODE_ABORT_IRQ: begin
        stbNext.entry   = evt.pinRise;
        stbNext.recover = evt.pinFall;
      end
      MODE_GP_IRQ:    stbNext.gpi = evt.pinFall;
      default:        stbNext = '0;
    endcase
    rxEnable = !(((mode == MODE_GATE_ONLY) || (mode == MODE_ABORT_IRQ)) && evt.pinLevel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stb <= '0;
    else       stb <= stbNext;
  end

  assert_entry_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.entry |-> (evt.pinLevel && $past(evt.sampleStb)));

  assert_recover_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.recover |-> !evt.pinLevel);

  assert_gp_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.gpi |-> !evt.pinLevel);

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb != '0) |=> (stb == '0));

endmodule

// File: rtl/oof_mon_status.sv
module oof_mon_status
  import oof_mon_pkg::*;
#(
  parameter int NSRC = IRQ_SRC
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] setVec,
  input  logic            clrWe,
  input  logic [NSRC-1:0] clrData,
  output logic [NSRC-1:0] statusQ,
  output logic            irq
);

  logic [NSRC-1:0] clrMask;

  always_comb clrMask = clrWe ? clrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | setVec;
  end

  always_comb irq = |statusQ;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> statusQ[i]);
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rstN)
      (clrWe && clrData[i] && !setVec[i]) |=> !statusQ[i]);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !(clrWe && clrData[i])) |=> statusQ[i]);
  end

endmodule

// File: rtl/oof_monitor.sv
module oof_monitor
  import oof_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxClk,
  input  logic               oofPin,
  input  logic               cfgFallEdge,
  input  logic               cfgAbort,
  input  logic               cfgIntEn,
  input  logic               statusClrWe,
  input  logic [IRQ_SRC-1:0] statusClrData,
  output logic               rxEnable,
  output logic               oofEntryPulse,
  output logic               frameRecPulse,
  output logic               gpIrqPulse,
  output logic [IRQ_SRC-1:0] statusBits,
  output logic               irq
);

  sampleEvt_t         evt;
  irqStb_t            stb;
  logic [IRQ_SRC-1:0] setVec;

  oof_mon_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxClk       (rxClk),
    .oofPin      (oofPin),
    .cfgFallEdge (cfgFallEdge),
    .evt         (evt)
  );

  oof_mon_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .cfgAbort (cfgAbort),
    .cfgIntEn (cfgIntEn),
    .stb      (stb),
    .rxEnable (rxEnable)
  );

  always_comb begin
    setVec            = '0;
    setVec[ENTRY_IDX] = stb.entry;
    setVec[REC_IDX]   = stb.recover;
    setVec[GP_IDX]    = stb.gpi;
    oofEntryPulse     = stb.entry;
    frameRecPulse     = stb.recover;
    gpIrqPulse        = stb.gpi;
  end

  oof_mon_status #(.NSRC(IRQ_SRC)) status_i (
    .clk     (clk),
    .rstN    (rstN),
    .setVec  (setVec),
    .clrWe   (statusClrWe),
    .clrData (statusClrData),
    .statusQ (statusBits),
    .irq     (irq)
  );

endmodule

// File: tb/oof_monitor_tb.sv
module oof_monitor_tb_top;

  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;
  localparam int HALF = 6;
  localparam int NVEC = 11;

  // [6]abort [5]intEn [4]pin [3]expEntry [2]expRec [1]expGp [0]expRxEn
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1_1_1_1_0_0_0,
    7'b1_1_0_0_1_0_1,
    7'b1_0_1_0_0_0_0,
    7'b1_0_0_0_0_0_1,
    7'b0_1_1_0_0_0_1,
    7'b0_1_0_0_0_1_1,
    7'b0_0_1_0_0_0_1,
    7'b0_0_0_0_0_0_1,
    7'b1_1_1_1_0_0_0,
    7'b1_1_1_0_0_0_0,
    7'b0_1_0_0_0_1_1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxClk = 1'b0;
  logic oofPin = 1'b0;
  logic cfgFallEdge = 1'b0;
  logic cfgAbort = 1'b0;
  logic cfgIntEn = 1'b0;
  logic statusClrWe = 1'b0;
  logic [2:0] statusClrData = '0;
  logic rxEnable, oofEntryPulse, frameRecPulse, gpIrqPulse, irq;
  logic [2:0] statusBits;

  int checks = 0;
  int errors = 0;
  int cntEntry, cntRec, cntGp;

  always #10 clk = ~clk;

  oof_monitor #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rstN(rstN), .rxClk(rxClk), .oofPin(oofPin),
    .cfgFallEdge(cfgFallEdge), .cfgAbort(cfgAbort), .cfgIntEn(cfgIntEn),
    .statusClrWe(statusClrWe), .statusClrData(statusClrData),
    .rxEnable(rxEnable), .oofEntryPulse(oofEntryPulse),
    .frameRecPulse(frameRecPulse), .gpIrqPulse(gpIrqPulse),
    .statusBits(statusBits), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic countPulses();
    cntEntry += int'(oofEntryPulse);
    cntRec   += int'(frameRecPulse);
    cntGp    += int'(gpIrqPulse);
  endtask

  // one full receive clock period, counting pulses at every falling system edge
  task automatic rxCycle();
    cntEntry = 0; cntRec = 0; cntGp = 0;
    @(negedge clk) rxClk = 1'b1;
    for (int i = 0; i < HALF; i++) begin @(negedge clk); countPulses(); end
    rxClk = 1'b0;
    for (int i = 0; i < HALF; i++) begin @(negedge clk); countPulses(); end
  endtask

  task automatic clearStatus(input logic [2:0] mask);
    @(negedge clk);
    statusClrWe = 1'b1; statusClrData = mask;
    @(negedge clk);
    statusClrWe = 1'b0; statusClrData = '0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R3 reset rxEnable", int'(rxEnable), 1);
    chk("R8 reset status", int'(statusBits), 0);
    chk("R9 reset irq", int'(irq), 0);
    chk("R7 reset pulses", int'({oofEntryPulse, frameRecPulse, gpIrqPulse}), 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      cfgAbort = VEC[v][6]; cfgIntEn = VEC[v][5]; oofPin = VEC[v][4];
      repeat (3) @(negedge clk);
      rxCycle();
      chk($sformatf("R2 vec%0d entry count", v), cntEntry, int'(VEC[v][3]));
      chk($sformatf("R4 vec%0d recovery count", v), cntRec, int'(VEC[v][2]));
      chk($sformatf("R5 R6 vec%0d gp count", v), cntGp, int'(VEC[v][1]));
      chk($sformatf("R3 vec%0d rxEnable", v), int'(rxEnable), int'(VEC[v][0]));
      chk($sformatf("R8 vec%0d status", v), int'(statusBits),
          int'({VEC[v][1], VEC[v][2], VEC[v][3]}));
      chk($sformatf("R9 vec%0d irq", v), int'(irq), int'(|VEC[v][3:1]));
      clearStatus(3'b111);
      chk($sformatf("R8 vec%0d cleared", v), int'(statusBits), 0);
    end

    // R10 exact latency (pin sample currently 0)
    @(negedge clk);
    cfgAbort = 1'b1; cfgIntEn = 1'b1; oofPin = 1'b1;
    repeat (3) @(negedge clk);
    rxClk = 1'b1;
    repeat (LAT - 1) @(negedge clk);
    chk("R10 no early pulse", int'(oofEntryPulse), 0);
    chk("R10 no early gate", int'(rxEnable), 1);
    @(negedge clk);
    chk("R10 entry pulse due", int'(oofEntryPulse), 1);
    chk("R10 gate due", int'(rxEnable), 0);
    chk("R10 status not yet", int'(statusBits), 0);
    @(negedge clk);
    chk("R7 pulse one cycle", int'(oofEntryPulse), 0);
    chk("R10 status due", int'(statusBits), 1);
    chk("R9 irq set", int'(irq), 1);
    repeat (HALF) @(negedge clk);
    rxClk = 1'b0;
    repeat (HALF) @(negedge clk);

    // R8 partial clear, set bits kept apart
    oofPin = 1'b0;
    repeat (3) @(negedge clk);
    rxCycle();
    chk("R4 recovery pulse", cntRec, 1);
    chk("R8 two bits set", int'(statusBits), 3);
    clearStatus(3'b001);
    chk("R8 clear bit0 only", int'(statusBits), 2);
    chk("R9 irq still set", int'(irq), 1);
    clearStatus(3'b010);
    chk("R8 clear bit1", int'(statusBits), 0);
    chk("R9 irq released", int'(irq), 0);

    // R1 falling-edge selection
    @(negedge clk);
    cfgFallEdge = 1'b1; oofPin = 1'b1;
    repeat (3) @(negedge clk);
    cntEntry = 0;
    rxClk = 1'b1;
    for (int i = 0; i < HALF; i++) begin @(negedge clk); countPulses(); end
    chk("R1 rising edge not sampled", cntEntry, 0);
    chk("R1 gate unchanged on rising", int'(rxEnable), 1);
    rxClk = 1'b0;
    for (int i = 0; i < HALF; i++) begin @(negedge clk); countPulses(); end
    chk("R1 falling edge sampled", cntEntry, 1);
    chk("R1 gate on falling", int'(rxEnable), 0);
    clearStatus(3'b111);

    // R1 glitch between selected edges is invisible
    cntEntry = 0; cntRec = 0;
    oofPin = 1'b0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); countPulses(); end
    oofPin = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); countPulses(); end
    chk("R1 glitch no recovery", cntRec, 0);
    chk("R1 glitch gate held", int'(rxEnable), 0);
    rxCycle();
    chk("R7 repeated sample no pulse", cntEntry + cntRec, 0);
    chk("R8 status untouched", int'(statusBits), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule